// File: doc/BRIEF.md
# Indirect-Addressed Video Control Register File

This block is the processor-facing register bank of a video colour-lookup and DAC controller. A host on a narrow parallel bus reaches every register through a pointer. A control-phase write (select line high) loads an 8-bit index. Each later data-phase access (select line low) reads or writes the register at that index. The bank holds:

- two read-only capture registers that sample the pixel port and the DAC port for diagnostics;
- a fixed identification byte;
- a pixel mask;
- a three-bit sync/blank/aux control field;
- a command register whose sync-output enable and calibration request go to the pixel path.

All strobes are sampled on the rising clock edge while the chip select is high. Read data is registered and appears on the data bus one cycle after the read strobe. It holds there until the next read. Capture registers wider than the bus are read as successive bytes, low byte first. A byte counter steps the sequence and goes back to the low byte whenever the pointer is rewritten. Indices with no register behind them ignore writes and read as zero.

Top module: `vidctl_regfile`

## Requirements
- R1: After synchronous reset, the pointer is 00h, `pix_mask` is FFh, `sbi_ctl` is 000b, `sync_out_en` and `cal_req` are 0, and `bus_rdata` is 00h.
- R2: A write with `bus_ctl`=1 loads `bus_wdata` into the pointer. A read with `bus_ctl`=1 returns the pointer on `bus_rdata` in the following cycle.
- R3: The result of any read appears on `bus_rdata` in the cycle after the strobe edge. `bus_rdata` keeps its value in every cycle that has no read.
- R4: Index 00h, the pixel capture register, returns red, green and blue on three successive data reads, then wraps to red.
- R5: Index 01h, the DAC capture register, holds the 30-bit word {blue, green, red} with red in bits 9:0. Four successive reads return bits 7:0, 15:8 and 23:16, then {00b, bits 29:24}, and the sequence then wraps.
- R6: Any pointer write returns the byte counter to the low byte.
- R7: While `cap_en` is 1, both capture registers load their ports on every clock. While `cap_en` is 0 they hold. Data writes to indices 00h, 01h and 03h change nothing.
- R8: Index 02h stores `bus_wdata[2:0]` into `sbi_ctl` (bit 0 sync, bit 1 blank, bit 2 aux). Write bits 7:3 are dropped, and a read returns {00000b, sbi_ctl}.
- R9: Index 03h always reads 8Eh.
- R10: Index 04h is an 8-bit read/write mask driven on `pix_mask`.
- R11: Index 05h keeps only bit 0 (calibrate) and bit 2 (sync enable) of a write, and all other bits read as zero. `sync_out_en` equals stored bit 2.
- R12: `cal_req` is 1 only when stored command bit 0 is 1 and `cal_inhibit` is 0.
- R13: Indices 06h to FFh ignore data writes and read 00h.
- R14: Strobes with `bus_sel`=0 have no effect. When read and write are both asserted, only the write takes place and `bus_rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_ctl | input | 1 | 1: pointer access, 0: data access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_en | input | 1 | Capture enable for test readback |
| pix_r | input | 8 | Pixel port, red |
| pix_g | input | 8 | Pixel port, green |
| pix_b | input | 8 | Pixel port, blue |
| dac_r | input | 10 | DAC port, red |
| dac_g | input | 10 | DAC port, green |
| dac_b | input | 10 | DAC port, blue |
| cal_inhibit | input | 1 | Mode bit that blocks calibration when 1 |
| pix_mask | output | 8 | Pixel mask to the pixel path |
| sbi_ctl | output | 3 | Sync, blank, aux control bits |
| sync_out_en | output | 1 | Sync output enable (0 = high impedance) |
| cal_req | output | 1 | Calibration request |

## Verification
The bound checker watches several rules on every cycle:
- the post-reset values;
- that the read bus, mask, control field and sync enable change only after the kind of access allowed to change them;
- that a pointer read echoes the pointer;
- that the identification index reads 8Eh and unmapped indices read zero;
- that a calibration request never appears while inhibited.

Only the bench's scenarios can show the byte order and wrap of the capture registers, the counter reset on a pointer write, capture hold, and the masking of command and control bits to their stored fields. These scenarios are compared against a behavioural model on every clock.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    localparam int BUS_W = 8;
    localparam int PIX_W = 8;
    localparam int DAC_W = 10;
    localparam int NCH   = 3;
    localparam int SBI_W = 3;

    localparam logic [BUS_W-1:0] IDX_PIXCAP = 8'h00;
    localparam logic [BUS_W-1:0] IDX_DACCAP = 8'h01;
    localparam logic [BUS_W-1:0] IDX_SBI    = 8'h02;
    localparam logic [BUS_W-1:0] IDX_IDENT  = 8'h03;
    localparam logic [BUS_W-1:0] IDX_MASK   = 8'h04;
    localparam logic [BUS_W-1:0] IDX_CMD    = 8'h05;

    localparam logic [BUS_W-1:0] IDENT_VAL = 8'h8E;
    localparam logic [BUS_W-1:0] MASK_RST  = 8'hFF;

    localparam int CMD_CAL_BIT  = 0;
    localparam int CMD_SYNC_BIT = 2;

    typedef struct packed {
        logic             ptr_wr;
        logic             ptr_rd;
        logic             dat_wr;
        logic             dat_rd;
        logic [BUS_W-1:0] wdata;
    } bus_evt_t;

    typedef struct packed {
        logic sync_en;
        logic cal;
    } cmd_t;

    function automatic int bytes_for(input int bits);
        return (bits + BUS_W - 1) / BUS_W;
    endfunction

    function automatic logic [BUS_W-1:0] cmd_readback(input cmd_t c);
        logic [BUS_W-1:0] v;
        v = '0;
        v[CMD_CAL_BIT]  = c.cal;
        v[CMD_SYNC_BIT] = c.sync_en;
        return v;
    endfunction

endpackage

// File: rtl/vidctl_bus_decode.sv
module vidctl_bus_decode
    import vidctl_pkg::*;
(
    input  logic             bus_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_ctl,
    input  logic [BUS_W-1:0] bus_wdata,
    output bus_evt_t         evt
);
    logic wr_ok, rd_ok;

    always_comb begin
        wr_ok      = bus_sel & bus_wr;
        rd_ok      = bus_sel & bus_rd & ~bus_wr;
        evt.ptr_wr = wr_ok & bus_ctl;
        evt.dat_wr = wr_ok & ~bus_ctl;
        evt.ptr_rd = rd_ok & bus_ctl;
        evt.dat_rd = rd_ok & ~bus_ctl;
        evt.wdata  = bus_wdata;
    end
endmodule

// File: rtl/vidctl_capture.sv
module vidctl_capture
    import vidctl_pkg::*;
#(
    parameter int CH_PIX_W = PIX_W,
    parameter int CH_DAC_W = DAC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap_en,
    input  logic [NCH*CH_PIX_W-1:0] pix_in,
    input  logic [NCH*CH_DAC_W-1:0] dac_in,
    input  logic                    ptr_wr,
    input  logic                    dat_rd,
    input  logic [BUS_W-1:0]        ptr,
    output logic [BUS_W-1:0]        cap_byte
);
    localparam int PIX_BYTES = bytes_for(NCH * CH_PIX_W);
    localparam int DAC_BYTES = bytes_for(NCH * CH_DAC_W);
    localparam int MAX_BYTES = (PIX_BYTES > DAC_BYTES) ? PIX_BYTES : DAC_BYTES;
    localparam int CNT_W     = (MAX_BYTES > 2) ? $clog2(MAX_BYTES) : 1;
    localparam int PIX_PAD   = PIX_BYTES * BUS_W;
    localparam int DAC_PAD   = DAC_BYTES * BUS_W;
    localparam logic [CNT_W-1:0] PIX_LAST = CNT_W'(PIX_BYTES - 1);
    localparam logic [CNT_W-1:0] DAC_LAST = CNT_W'(DAC_BYTES - 1);

    logic [NCH*CH_PIX_W-1:0] pix_q;
    logic [NCH*CH_DAC_W-1:0] dac_q;
    logic [PIX_PAD-1:0]      pix_pad;
    logic [DAC_PAD-1:0]      dac_pad;
    logic [CNT_W-1:0]        cnt_q;
    logic                    sel_pix, sel_dac;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                pix_q[c*CH_PIX_W +: CH_PIX_W] <= '0;
                dac_q[c*CH_DAC_W +: CH_DAC_W] <= '0;
            end else if (cap_en) begin
                pix_q[c*CH_PIX_W +: CH_PIX_W] <= pix_in[c*CH_PIX_W +: CH_PIX_W];
                dac_q[c*CH_DAC_W +: CH_DAC_W] <= dac_in[c*CH_DAC_W +: CH_DAC_W];
            end
        end
    end

    assign sel_pix = (ptr == IDX_PIXCAP);
    assign sel_dac = (ptr == IDX_DACCAP);
    assign pix_pad = PIX_PAD'(pix_q);
    assign dac_pad = DAC_PAD'(dac_q);

    always_ff @(posedge clk) begin
        if (rst || ptr_wr) begin
            cnt_q <= '0;
        end else if (dat_rd && sel_pix) begin
            cnt_q <= (cnt_q == PIX_LAST) ? '0 : cnt_q + 1'b1;
        end else if (dat_rd && sel_dac) begin
            cnt_q <= (cnt_q == DAC_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        cap_byte = '0;
        if (sel_pix)
            cap_byte = pix_pad[cnt_q*BUS_W +: BUS_W];
        else if (sel_dac)
            cap_byte = dac_pad[cnt_q*BUS_W +: BUS_W];
    end
endmodule

// File: rtl/vidctl_ctrl_regs.sv
module vidctl_ctrl_regs
    import vidctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dat_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] ptr,
    output logic [BUS_W-1:0] mask_q,
    output logic [SBI_W-1:0] sbi_q,
    output cmd_t             cmd_q,
    output logic [BUS_W-1:0] ctrl_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RST;
            sbi_q  <= '0;
            cmd_q  <= '0;
        end else if (dat_wr) begin
            unique case (ptr)
                IDX_SBI:  sbi_q  <= wdata[SBI_W-1:0];
                IDX_MASK: mask_q <= wdata;
                IDX_CMD: begin
                    cmd_q.cal     <= wdata[CMD_CAL_BIT];
                    cmd_q.sync_en <= wdata[CMD_SYNC_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (ptr)
            IDX_SBI:  ctrl_byte = BUS_W'(sbi_q);
            IDX_MASK: ctrl_byte = mask_q;
            IDX_CMD:  ctrl_byte = cmd_readback(cmd_q);
            default:  ctrl_byte = '0;
        endcase
    end
endmodule

// File: rtl/vidctl_regfile.sv
module vidctl_regfile
    import vidctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_ctl,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cap_en,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    input  logic [DAC_W-1:0] dac_r,
    input  logic [DAC_W-1:0] dac_g,
    input  logic [DAC_W-1:0] dac_b,
    input  logic             cal_inhibit,
    output logic [BUS_W-1:0] pix_mask,
    output logic [SBI_W-1:0] sbi_ctl,
    output logic             sync_out_en,
    output logic             cal_req
);
    bus_evt_t         evt;
    logic [BUS_W-1:0] ptr_q;
    logic [BUS_W-1:0] cap_byte;
    logic [BUS_W-1:0] ctrl_byte;
    logic [BUS_W-1:0] data_byte;
    cmd_t             cmd_q;

    vidctl_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_ctl  (bus_ctl),
        .bus_wdata(bus_wdata),
        .evt      (evt)
    );

    vidctl_capture #(.CH_PIX_W(PIX_W), .CH_DAC_W(DAC_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .pix_in  ({pix_b, pix_g, pix_r}),
        .dac_in  ({dac_b, dac_g, dac_r}),
        .ptr_wr  (evt.ptr_wr),
        .dat_rd  (evt.dat_rd),
        .ptr     (ptr_q),
        .cap_byte(cap_byte)
    );

    vidctl_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .dat_wr   (evt.dat_wr),
        .wdata    (evt.wdata),
        .ptr      (ptr_q),
        .mask_q   (pix_mask),
        .sbi_q    (sbi_ctl),
        .cmd_q    (cmd_q),
        .ctrl_byte(ctrl_byte)
    );

    always_comb begin
        data_byte = cap_byte | ctrl_byte;
        if (ptr_q == IDX_IDENT)
            data_byte = IDENT_VAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (evt.ptr_wr)
                ptr_q <= evt.wdata;
            if (evt.ptr_rd)
                bus_rdata <= ptr_q;
            else if (evt.dat_rd)
                bus_rdata <= data_byte;
        end
    end

    assign sync_out_en = cmd_q.sync_en;
    assign cal_req     = cmd_q.cal & ~cal_inhibit;
endmodule

// File: rtl/vidctl_regfile_chk.sv
module vidctl_regfile_chk
    import vidctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_ctl,
    input logic [BUS_W-1:0] bus_rdata,
    input logic [BUS_W-1:0] pix_mask,
    input logic [SBI_W-1:0] sbi_ctl,
    input logic             sync_out_en,
    input logic             cal_req,
    input logic             cal_inhibit,
    input logic [BUS_W-1:0] ptr
);
    logic any_rd, dat_rd, dat_wr, ptr_rd;
    assign any_rd = bus_sel & bus_rd & ~bus_wr;
    assign dat_rd = any_rd & ~bus_ctl;
    assign ptr_rd = any_rd & bus_ctl;
    assign dat_wr = bus_sel & bus_wr & ~bus_ctl;

    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix_mask == MASK_RST && sbi_ctl == '0 && !sync_out_en
                        && !cal_req && bus_rdata == '0));

    // R2
    ptr_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ptr_rd)) |-> bus_rdata == $past(ptr));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(bus_rdata)) |-> $past(any_rd));

    // R8
    sbi_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sbi_ctl)) |-> $past(dat_wr && ptr == IDX_SBI));

    // R9
    ident_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dat_rd && ptr == IDX_IDENT)) |-> bus_rdata == IDENT_VAL);

    // R10
    mask_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(pix_mask)) |-> $past(dat_wr && ptr == IDX_MASK));

    // R11
    sync_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sync_out_en)) |-> $past(dat_wr && ptr == IDX_CMD));

    // R12
    cal_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        cal_req |-> !cal_inhibit);

    // R13
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dat_rd && ptr > IDX_CMD)) |-> bus_rdata == '0);
endmodule

bind vidctl_regfile vidctl_regfile_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_ctl    (bus_ctl),
    .bus_rdata  (bus_rdata),
    .pix_mask   (pix_mask),
    .sbi_ctl    (sbi_ctl),
    .sync_out_en(sync_out_en),
    .cal_req    (cal_req),
    .cal_inhibit(cal_inhibit),
    .ptr        (ptr_q)
);

// File: tb/vidctl_regfile_bench.sv
module vidctl_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_rd, bus_wr, bus_ctl;
    logic [7:0] bus_wdata, bus_rdata;
    logic       cap_en, cal_inhibit;
    logic [7:0] pix_r, pix_g, pix_b;
    logic [9:0] dac_r, dac_g, dac_b;
    logic [7:0] pix_mask;
    logic [2:0] sbi_ctl;
    logic       sync_out_en, cal_req;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vidctl_regfile u_vidctl_regfile (.*);

    // Behavioural reference model
    int         m_ptr, m_cnt, m_mask, m_sbi, m_rd;
    bit         m_cal, m_sync;
    longint     m_pix, m_dac;

    always @(posedge clk) begin
        if (rst) begin
            m_ptr = 0; m_cnt = 0; m_mask = 255; m_sbi = 0; m_rd = 0;
            m_cal = 0; m_sync = 0; m_pix = 0; m_dac = 0;
        end else begin
            if (bus_sel && bus_wr) begin
                if (bus_ctl) begin
                    m_ptr = bus_wdata; m_cnt = 0;
                end else if (m_ptr == 2) m_sbi = bus_wdata % 8;
                else if (m_ptr == 4) m_mask = bus_wdata;
                else if (m_ptr == 5) begin
                    m_cal = bus_wdata[0]; m_sync = bus_wdata[2];
                end
            end else if (bus_sel && bus_rd) begin
                if (bus_ctl) m_rd = m_ptr;
                else if (m_ptr == 0) begin
                    m_rd = int'((m_pix >> (8 * m_cnt)) & 255);
                    m_cnt = (m_cnt + 1) % 3;
                end else if (m_ptr == 1) begin
                    m_rd = int'((m_dac >> (8 * m_cnt)) & 255);
                    m_cnt = (m_cnt + 1) % 4;
                end else if (m_ptr == 2) m_rd = m_sbi;
                else if (m_ptr == 3) m_rd = 142;
                else if (m_ptr == 4) m_rd = m_mask;
                else if (m_ptr == 5) m_rd = (m_sync ? 4 : 0) + (m_cal ? 1 : 0);
                else m_rd = 0;
            end
            if (cap_en) begin
                m_pix = (longint'(pix_b) << 16) + (longint'(pix_g) << 8) + pix_r;
                m_dac = (longint'(dac_b) << 20) + (longint'(dac_g) << 10) + dac_r;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 model rdata", bus_rdata, m_rd);
            check("R10 model mask", pix_mask, m_mask);
            check("R8 model sbi", sbi_ctl, m_sbi);
            check("R11 model sync", sync_out_en, m_sync);
            check("R12 model cal", cal_req, m_cal && !cal_inhibit);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL R3 watchdog actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic acc(input bit sel, input bit rd, input bit wr, input bit ctl,
                       input logic [7:0] d);
        bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_ctl = ctl; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_ctl = 0; bus_wdata = 8'h00;
    endtask

    task automatic set_ptr(input logic [7:0] p); acc(1, 0, 1, 1, p); endtask
    task automatic wr_dat(input logic [7:0] d);  acc(1, 0, 1, 0, d); endtask
    task automatic rd_dat;                       acc(1, 1, 0, 0, 8'h00); endtask

    initial begin
        logic [31:0] dw;
        rst = 1; bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_ctl = 0; bus_wdata = 0;
        cap_en = 0; cal_inhibit = 0;
        pix_r = 0; pix_g = 0; pix_b = 0; dac_r = 0; dac_g = 0; dac_b = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 mask", pix_mask, 8'hFF);
        check("R1 sbi", sbi_ctl, 0);
        check("R1 sync", sync_out_en, 0);
        check("R1 cal", cal_req, 0);

        // R2 pointer load and echo
        set_ptr(8'h05);
        acc(1, 1, 0, 1, 8'h00);
        check("R2 ptr echo", bus_rdata, 8'h05);
        // R3 hold while idle
        repeat (3) @(negedge clk);
        check("R3 hold", bus_rdata, 8'h05);

        // R7 capture then hold
        pix_r = 8'h11; pix_g = 8'h22; pix_b = 8'h33;
        dac_r = 10'h3A5; dac_g = 10'h15A; dac_b = 10'h2C3;
        cap_en = 1; @(negedge clk); cap_en = 0;
        pix_r = 8'hEE; pix_g = 8'hDD; pix_b = 8'hCC; dac_r = 0; dac_g = 0; dac_b = 0;

        // R4 pixel bytes and wrap
        set_ptr(8'h00);
        rd_dat; check("R4 red", bus_rdata, 8'h11);
        rd_dat; check("R4 green", bus_rdata, 8'h22);
        rd_dat; check("R4 blue", bus_rdata, 8'h33);
        rd_dat; check("R4 wrap", bus_rdata, 8'h11);

        // R5 DAC bytes and wrap
        dw = {2'b00, 10'h2C3, 10'h15A, 10'h3A5};
        set_ptr(8'h01);
        for (int i = 0; i < 4; i++) begin
            rd_dat; check("R5 dac byte", bus_rdata, dw[8*i +: 8]);
        end
        rd_dat; check("R5 wrap", bus_rdata, dw[7:0]);

        // R6 pointer rewrite resets byte counter
        set_ptr(8'h00);
        rd_dat; rd_dat;
        set_ptr(8'h00);
        rd_dat; check("R6 restart", bus_rdata, 8'h11);

        // R7 writes to read-only indices ignored
        set_ptr(8'h00); wr_dat(8'hFF);
        rd_dat; check("R7 ro pixcap", bus_rdata, 8'h11);

        // R8 sbi field
        set_ptr(8'h02); wr_dat(8'hFD);
        check("R8 sbi out", sbi_ctl, 3'b101);
        rd_dat; check("R8 sbi read", bus_rdata, 8'h05);

        // R9 identification
        set_ptr(8'h03); wr_dat(8'h00);
        rd_dat; check("R9 ident", bus_rdata, 8'h8E);

        // R10 mask
        set_ptr(8'h04); wr_dat(8'h3C);
        check("R10 mask out", pix_mask, 8'h3C);
        rd_dat; check("R10 mask read", bus_rdata, 8'h3C);

        // R11 / R12 command
        set_ptr(8'h05); wr_dat(8'hFF);
        rd_dat; check("R11 cmd read", bus_rdata, 8'h05);
        check("R11 sync en", sync_out_en, 1);
        check("R12 cal on", cal_req, 1);
        cal_inhibit = 1; #1;
        check("R12 cal inhibited", cal_req, 0);
        cal_inhibit = 0;
        wr_dat(8'hFA);
        check("R11 cmd clear bit0", cal_req, 0);
        rd_dat; check("R11 cmd read2", bus_rdata, 8'h00);

        // R13 unmapped indices
        set_ptr(8'h09); wr_dat(8'hAA);
        rd_dat; check("R13 idx09", bus_rdata, 8'h00);
        set_ptr(8'h06); wr_dat(8'h55);
        rd_dat; check("R13 idx06", bus_rdata, 8'h00);
        check("R13 mask untouched", pix_mask, 8'h3C);

        // R14 simultaneous strobes and deselected access
        set_ptr(8'h04);
        rd_dat; check("R14 pre", bus_rdata, 8'h3C);
        acc(1, 1, 1, 0, 8'h55);
        check("R14 write wins", pix_mask, 8'h55);
        check("R14 rdata held", bus_rdata, 8'h3C);
        acc(0, 0, 1, 0, 8'h99);
        check("R14 desel write", pix_mask, 8'h55);
        acc(0, 1, 0, 0, 8'h00);
        check("R14 desel read", bus_rdata, 8'h3C);

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule